// File: doc/BRIEF.md
# Excess-3 Decimal Adder-Subtractor

This block adds or subtracts two multi-digit decimal numbers held in excess-3 form, where each decimal digit d occupies four bits as the code d+3. Addition sums every digit pair in plain binary, ripples the carries upward from the least significant digit, and then moves each raw digit back into excess-3 form with +3 or -3, chosen by that digit's own carry out. Subtraction inverts the subtrahend, which forms its nines complement in excess-3. A final carry of 1 means the difference is positive. That carry re-enters at the least significant digit, which is done here as a second addition pass with carry-in 1. A final carry of 0 means the difference is negative, and the corrected digits are inverted to give the magnitude.

The operands, the operation select and an input strobe arrive together. The result, the flags and a one-cycle result strobe appear one clock later. Any operand digit that is not a legal excess-3 code raises an error flag. A small two-state controller produces the result strobe. State `ST_IDLE` moves to `ST_PRESENT` on an input strobe. `ST_PRESENT` stays in `ST_PRESENT` on a further strobe and goes back to `ST_IDLE` when no strobe arrives. Reset forces `ST_IDLE`.

Top module: `xs3_addsub`

## Requirements
- R1: A synchronous active-high reset clears `res` to all zeros, and clears `carry_out`, `neg`, `bad_digit` and `out_valid` to 0.
- R2: `out_valid` is 1 in exactly those cycles that directly follow a cycle in which `in_valid` was 1.
- R3: With `op_sub`=0, one clock after the strobe, `res` holds (A+B) mod 10^N in excess-3, with each digit d coded as d+3 and the least significant digit in bits [3:0]. `carry_out` is 1 exactly when A+B ≥ 10^N, and `neg` is 0.
- R4: With `op_sub`=1 and A > B, `res` holds A−B in excess-3, `neg` is 0 and `carry_out` is 0.
- R5: With `op_sub`=1 and A < B, `res` holds the magnitude B−A in excess-3, `neg` is 1 and `carry_out` is 0.
- R6: With `op_sub`=1 and A = B, including 0−0, `res` holds zero (every digit 0011) and `neg` is 1.
- R7: `bad_digit` is 1 one clock after a strobe exactly when some digit of either operand is below 0011 or above 1100. The other result fields are then unspecified.
- R8: When both operands hold only legal codes, every digit of `res` is a legal excess-3 code (0011 to 1100).
- R9: In a cycle without `in_valid`, `res`, `carry_out`, `neg` and `bad_digit` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (opa − opb) |
| opa | input | 4*NDIG | First operand, packed excess-3 digits, least significant in [3:0] |
| opb | input | 4*NDIG | Second operand, same layout |
| res | output | 4*NDIG | Excess-3 sum, difference or magnitude |
| carry_out | output | 1 | Decimal overflow of an addition |
| neg | output | 1 | The difference is negative, so `res` is its magnitude |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| bad_digit | output | 1 | An operand contained a non-excess-3 code |

## Verification
The digit-range assertion takes for granted that an error-free strobe carries operands built only from codes 0011 to 1100. The flag assertions take for granted that `op_sub` is sampled together with `in_valid`. The stimulus keeps to this: the exhaustive sweep encodes every two-digit decimal value as d+3, and illegal codes appear only in table rows that expect `bad_digit`, where only the error flag is compared. Every input change happens on the falling edge, so the operands and the select are stable at the capturing edge.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
    localparam int DW = 4;
    localparam logic [DW-1:0] CODE_LO = 4'd3;
    localparam logic [DW-1:0] CODE_HI = 4'd12;
    localparam logic [DW-1:0] FIX_UP = 4'd3;
    localparam logic [DW-1:0] FIX_DOWN = 4'd13;

    typedef enum logic {
        ST_IDLE,
        ST_PRESENT
    } ctl_state_t;

    function automatic logic code_ok(input logic [DW-1:0] c);
        return (c >= CODE_LO) && (c <= CODE_HI);
    endfunction
endpackage

// File: rtl/xs3_ripple.sv
module xs3_ripple #(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    input  logic              cin,
    output logic [4*NDIG-1:0] raw,
    output logic [NDIG-1:0]   cy
);
    logic [NDIG:0] chain;
    assign chain[0] = cin;

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        logic [4:0] part;
        assign part = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'b0, chain[d]};
        assign raw[4*d +: 4] = part[3:0];
        assign cy[d] = part[4];
        assign chain[d+1] = part[4];
    end
endmodule

// File: rtl/xs3_fix.sv
module xs3_fix
    import xs3_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] raw,
    input  logic [NDIG-1:0]   cy,
    input  logic              invert,
    output logic [4*NDIG-1:0] fixed
);
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        logic [3:0] adj;
        assign adj = raw[4*d +: 4] + (cy[d] ? FIX_UP : FIX_DOWN);
        assign fixed[4*d +: 4] = invert ? ~adj : adj;
    end
endmodule

// File: rtl/xs3_check.sv
module xs3_check
    import xs3_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] opa,
    input  logic [4*NDIG-1:0] opb,
    output logic              bad
);
    logic [NDIG-1:0] bad_vec;

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        assign bad_vec[d] = !code_ok(opa[4*d +: 4]) || !code_ok(opb[4*d +: 4]);
    end

    assign bad = |bad_vec;
endmodule

// File: rtl/xs3_addsub.sv
module xs3_addsub
    import xs3_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [4*NDIG-1:0] opa,
    input  logic [4*NDIG-1:0] opb,
    output logic [4*NDIG-1:0] res,
    output logic              carry_out,
    output logic              neg,
    output logic              out_valid,
    output logic              bad_digit
);
    localparam int W = 4 * NDIG;

    ctl_state_t state;

    logic [W-1:0]    addend;
    logic [W-1:0]    raw_first;
    logic [W-1:0]    raw_second;
    logic [NDIG-1:0] cy_first;
    logic [NDIG-1:0] cy_second;
    logic [W-1:0]    raw_sel;
    logic [NDIG-1:0] cy_sel;
    logic [W-1:0]    fixed;
    logic            top_carry;
    logic            end_around;
    logic            borrow;
    logic            bad_any;

    assign addend = op_sub ? ~opb : opb;

    xs3_ripple #(.NDIG(NDIG)) u_pass_first (
        .a(opa), .b(addend), .cin(1'b0), .raw(raw_first), .cy(cy_first)
    );

    xs3_ripple #(.NDIG(NDIG)) u_pass_second (
        .a(opa), .b(addend), .cin(1'b1), .raw(raw_second), .cy(cy_second)
    );

    assign top_carry  = cy_first[NDIG-1];
    assign end_around = op_sub & top_carry;
    assign borrow     = op_sub & ~top_carry;
    assign raw_sel    = end_around ? raw_second : raw_first;
    assign cy_sel     = end_around ? cy_second : cy_first;

    xs3_fix #(.NDIG(NDIG)) u_fix (
        .raw(raw_sel), .cy(cy_sel), .invert(borrow), .fixed(fixed)
    );

    xs3_check #(.NDIG(NDIG)) u_check (
        .opa(opa), .opb(opb), .bad(bad_any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state <= in_valid ? ST_PRESENT : ST_IDLE;
                ST_PRESENT: state <= in_valid ? ST_PRESENT : ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // result and flag registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res       <= '0;
            carry_out <= 1'b0;
            neg       <= 1'b0;
            bad_digit <= 1'b0;
        end else if (in_valid) begin
            res       <= fixed;
            carry_out <= ~op_sub & top_carry;
            neg       <= borrow;
            bad_digit <= bad_any;
        end
    end

    assign out_valid = (state == ST_PRESENT);

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    add_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sub) |=> !neg);
    // R4
    sub_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sub) |=> !carry_out);
    // R7
    bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (bad_digit == $past(bad_any)));
    // R9
    hold_res_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res) && $stable(neg) && $stable(carry_out)));

    for (genvar d = 0; d < NDIG; d++) begin : g_rng
        // R8
        digit_range_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !bad_any) |=> code_ok(res[4*d +: 4]));
    end
endmodule

// File: tb/xs3_addsub_test.sv
module xs3_addsub_test;
    localparam int ND = 2;
    localparam int W = 4 * ND;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res;
    logic         carry_out;
    logic         neg;
    logic         out_valid;
    logic         bad_digit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xs3_addsub #(.NDIG(ND)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .res(res), .carry_out(carry_out),
        .neg(neg), .out_valid(out_valid), .bad_digit(bad_digit)
    );

    // row: op, a, b, expected res, carry, neg, bad
    localparam int NROW = 12;
    localparam logic [27:0] TABLE [NROW] = '{
        {1'b0, 8'h78, 8'h6B, 8'hB6, 1'b0, 1'b0, 1'b0},  // R3 45+38
        {1'b0, 8'hCC, 8'hCC, 8'hCB, 1'b1, 1'b0, 1'b0},  // R3 99+99
        {1'b0, 8'h83, 8'h83, 8'h33, 1'b1, 1'b0, 1'b0},  // R3 50+50
        {1'b1, 8'h33, 8'h33, 8'h33, 1'b0, 1'b1, 1'b0},  // R6 0-0
        {1'b1, 8'hCC, 8'h33, 8'hCC, 1'b0, 1'b0, 1'b0},  // R4 99-0
        {1'b1, 8'h33, 8'hCC, 8'hCC, 1'b0, 1'b1, 1'b0},  // R5 0-99
        {1'b1, 8'hA5, 8'h5A, 8'h78, 1'b0, 1'b0, 1'b0},  // R4 72-27
        {1'b1, 8'h5A, 8'hA5, 8'h78, 1'b0, 1'b1, 1'b0},  // R5 27-72
        {1'b1, 8'h74, 8'h74, 8'h33, 1'b0, 1'b1, 1'b0},  // R6 41-41
        {1'b0, 8'h2C, 8'h33, 8'h00, 1'b0, 1'b0, 1'b1},  // R7 low code
        {1'b1, 8'h3D, 8'h44, 8'h00, 1'b0, 1'b0, 1'b1},  // R7 high code
        {1'b0, 8'h44, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b1}   // R7 both
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] enc(input int v);
        logic [W-1:0] r;
        int t = v;
        for (int d = 0; d < ND; d++) begin
            r[4*d +: 4] = 4'((t % 10) + 3);
            t = t / 10;
        end
        return r;
    endfunction

    // drive at a falling edge, check at the next falling edge
    task automatic drive(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        op_sub = s;
        opa = a;
        opb = b;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "res", 32'(res), 32'(0));
        chk("R1", "flags", {28'(0), carry_out, neg, bad_digit, out_valid}, 32'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "idle strobe", 32'(out_valid), 32'(0));

        // table walk
        for (int i = 0; i < NROW; i++) begin
            logic [27:0] row = TABLE[i];
            drive(row[27], row[26:19], row[18:11]);
            chk("R2", "strobe", 32'(out_valid), 32'(1));
            chk("R7", "bad", 32'(bad_digit), 32'(row[0]));
            if (!row[0]) begin
                chk("R3", "table res", 32'(res), 32'(row[10:3]));
                chk("R4", "table carry", 32'(carry_out), 32'(row[2]));
                chk("R5", "table neg", 32'(neg), 32'(row[1]));
            end
        end

        // exhaustive sweep for two digits
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 100; a++) begin
                for (int b = 0; b < 100; b++) begin
                    int mag;
                    logic ec;
                    logic en;
                    if (s == 0) begin
                        mag = (a + b) % 100;
                        ec = (a + b) >= 100;
                        en = 1'b0;
                    end else if (a > b) begin
                        mag = a - b; ec = 1'b0; en = 1'b0;
                    end else begin
                        mag = b - a; ec = 1'b0; en = 1'b1;
                    end
                    drive(s[0], enc(a), enc(b));
                    checks++;
                    if (res !== enc(mag) || carry_out !== ec || neg !== en
                        || bad_digit !== 1'b0 || out_valid !== 1'b1) begin
                        errors++;
                        $display("FAIL %s op%0d %0d,%0d: actual %h/%b%b%b expected %h/%b%b0",
                                 (s == 0) ? "R3" : ((a > b) ? "R4" : ((a == b) ? "R6" : "R5")),
                                 s, a, b, res, carry_out, neg, bad_digit, enc(mag), ec, en);
                    end
                end
            end
        end

        // R8 all-legal result digits after a last legal operation
        chk("R8", "digit lo", 32'(res[3:0] >= 4'd3 && res[3:0] <= 4'd12), 32'(1));
        chk("R8", "digit hi", 32'(res[7:4] >= 4'd3 && res[7:4] <= 4'd12), 32'(1));

        // R9 hold: strobe off, inputs change, outputs keep values
        drive(1'b0, enc(12), enc(34));
        in_valid = 1'b0;
        op_sub = 1'b1;
        opa = 8'h2F;
        opb = enc(99);
        @(negedge clk);
        chk("R2", "strobe drop", 32'(out_valid), 32'(0));
        chk("R9", "held res", 32'(res), 32'(enc(46)));
        chk("R9", "held flags", {29'(0), carry_out, neg, bad_digit}, 32'(0));
        @(negedge clk);
        chk("R9", "still held", 32'(res), 32'(enc(46)));

        // R1 reset in the middle of a result
        drive(1'b1, enc(3), enc(8));
        chk("R5", "before reset", {23'(0), neg, res}, {23'(0), 1'b1, enc(5)});
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid reset res", 32'(res), 32'(0));
        chk("R1", "mid reset flags", {28'(0), carry_out, neg, bad_digit, out_valid}, 32'(0));
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule